// File: doc/BRIEF.md
# Masked per-pin GPIO configuration bank

This block is one bank of general-purpose I/O lines with a small register interface. It holds a configuration word for every line, but these words are not mapped one per address. Software first writes a line-select mask and then accesses a single configuration window. A write through the window stores the same settings into every selected line, so one bus write can program a whole group of pins. A read through the window returns the settings of one selected line.

The bank also holds an output latch. Software changes it through separate write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. Software reads the latch back through an output status register. A pin status register returns the pad inputs after a two-flop synchronizer. Each line's stored settings and latch value drive the pad-side outputs directly from flops.

The register bus uses a byte address, a write strobe, write data and registered read data. The address is as wide as one bank's 0x40-byte slot, so a parent decoder can place banks 0x40 apart.

Top module: `gcb_bank`

## Requirements
- R1: After reset, the mask, every configuration word, the output latch, the read data and all pad-side outputs are zero.
- R2: The mask register at offset 0x00 holds one bit per line (bit n selects line n) and reads back the value last written.
- R3: A write to the configuration window at offset 0x04 stores the written word into every line whose mask bit is 1; lines whose mask bit is 0 keep their configuration.
- R4: A read of the configuration window returns the word of the lowest-numbered line selected by the mask, and zero when the mask is empty.
- R5: Configuration word fields: function select [2:0] (0 is plain I/O), direction bit 8 (1 drives the pad), pull-up bit 9, pull-down bit 10, slew control bit 11, input filter bit 12, filter slow-clock select bit 13, open-drain bit 14, Schmitt control bit 15, drive strength [17:16]; all other bits are not stored and read as zero.
- R6: For each line n, pad_func[3n+2:3n], pad_dir[n], pad_pull_up[n], pad_pull_dn[n], pad_odrain[n] and pad_drive[2n+1:2n] equal the corresponding fields of line n's stored word.
- R7: A write to offset 0x10 sets each latch bit whose written bit is 1 and leaves the others unchanged.
- R8: A write to offset 0x14 clears each latch bit whose written bit is 1 and leaves the others unchanged.
- R9: The output status register at offset 0x18 reads the latch, pad_out equals the latch, and the latch changes only on writes to 0x10 or 0x14.
- R10: The pin status register at offset 0x08 returns pad_in through a two-flop synchronizer. A pad change made before clock edge k appears in read data that the read at edge k+2 registers.
- R11: Read data is registered: a read at an address presented at a clock edge appears on bus_rdata after that edge. Writes to 0x08, 0x18 or unmapped offsets change nothing. Unmapped offsets and the set and clear registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset within the bank |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output latch per line |
| pad_dir | output | 32 | Output enable per line |
| pad_func | output | 96 | Function select, 3 bits per line |
| pad_pull_up | output | 32 | Pull-up enable per line |
| pad_pull_dn | output | 32 | Pull-down enable per line |
| pad_odrain | output | 32 | Open-drain enable per line |
| pad_drive | output | 64 | Drive strength, 2 bits per line |

## Verification
The bench writes through masks that select several lines, a single line, no lines, and the top line together with a lower one. A design that wrote only one selected line, disturbed unselected lines, or picked the highest selected line for readback would give the wrong word in these checks. An all-ones configuration write exposes any reserved bit that is wrongly stored, and any field that is sent to the wrong pad output. The bench reads pin status on back-to-back cycles after a pad change, so a synchronizer with one flop too few or too many is caught. Writes to read-only and unmapped offsets are followed by reads of the latch, the mask and a configuration word, to confirm that these writes changed nothing.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

  localparam int REG_W = 32;
  localparam int CFG_BITS = 13;

  // register offsets inside one bank slot
  localparam logic [5:0] OFS_MASK = 6'h00;
  localparam logic [5:0] OFS_CFG  = 6'h04;
  localparam logic [5:0] OFS_PINS = 6'h08;
  localparam logic [5:0] OFS_SET  = 6'h10;
  localparam logic [5:0] OFS_CLR  = 6'h14;
  localparam logic [5:0] OFS_OUTS = 6'h18;

  // bits of the configuration word that hold state
  localparam logic [REG_W-1:0] CFG_IMPL = 32'h0003_FF07;

  typedef struct packed {
    logic [1:0] drive;
    logic       schmitt;
    logic       odrain;
    logic       filt_slow;
    logic       filt_en;
    logic       slew;
    logic       pull_dn;
    logic       pull_up;
    logic       dir;
    logic [2:0] func;
  } line_cfg_t;

  function automatic line_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    line_cfg_t c;
    c.func      = w[2:0];
    c.dir       = w[8];
    c.pull_up   = w[9];
    c.pull_dn   = w[10];
    c.slew      = w[11];
    c.filt_en   = w[12];
    c.filt_slow = w[13];
    c.odrain    = w[14];
    c.schmitt   = w[15];
    c.drive     = w[17:16];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input line_cfg_t c);
    logic [REG_W-1:0] w;
    w        = '0;
    w[2:0]   = c.func;
    w[8]     = c.dir;
    w[9]     = c.pull_up;
    w[10]    = c.pull_dn;
    w[11]    = c.slew;
    w[12]    = c.filt_en;
    w[13]    = c.filt_slow;
    w[14]    = c.odrain;
    w[15]    = c.schmitt;
    w[17:16] = c.drive;
    return w;
  endfunction

endpackage

// File: rtl/gcb_sync.sv
module gcb_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gcb_cfg_store.sv
module gcb_cfg_store
  import gcb_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [LINES-1:0]      sel,
  input  line_cfg_t             wcfg,
  output line_cfg_t [LINES-1:0] cfg_q
);
  // one register per line; a write may hit any subset of lines at once
  for (genvar n = 0; n < LINES; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)                cfg_q[n] <= '0;
      else if (we && sel[n])  cfg_q[n] <= wcfg;
    end
  end
endmodule

// File: rtl/gcb_lowest_pick.sv
module gcb_lowest_pick
  import gcb_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic      [LINES-1:0] sel,
  input  line_cfg_t [LINES-1:0] cfg,
  output line_cfg_t             picked
);
  logic [LINES-1:0] first_hot;
  line_cfg_t [LINES-1:0] gated;

  // isolate the lowest set bit
  assign first_hot = sel & (~sel + 1'b1);

  for (genvar n = 0; n < LINES; n++) begin : g_gate
    assign gated[n] = first_hot[n] ? cfg[n] : '0;
  end

  always_comb begin
    picked = '0;
    for (int n = 0; n < LINES; n++) picked = picked | gated[n];
  end
endmodule

// File: rtl/gcb_bank.sv
module gcb_bank
  import gcb_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int BANK_STRIDE = 64,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(BANK_STRIDE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [LINES-1:0]   pad_in,
  output logic [LINES-1:0]   pad_out,
  output logic [LINES-1:0]   pad_dir,
  output logic [3*LINES-1:0] pad_func,
  output logic [LINES-1:0]   pad_pull_up,
  output logic [LINES-1:0]   pad_pull_dn,
  output logic [LINES-1:0]   pad_odrain,
  output logic [2*LINES-1:0] pad_drive
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(OFS_PINS);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_OUTS = ADDR_W'(OFS_OUTS);

  function automatic logic [REG_W-1:0] widen(input logic [LINES-1:0] v);
    logic [REG_W-1:0] w;
    w = '0;
    w[LINES-1:0] = v;
    return w;
  endfunction

  logic [LINES-1:0]      mask_q;
  logic [LINES-1:0]      latch_q;
  logic [LINES-1:0]      pins_sync;
  line_cfg_t [LINES-1:0] cfg_q;
  line_cfg_t             cfg_rd;
  logic [REG_W-1:0]      rd_next;
  logic                  cfg_we;

  assign cfg_we = bus_wr && (bus_addr == A_CFG);

  gcb_cfg_store #(.LINES(LINES)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (mask_q),
    .wcfg  (word_to_cfg(bus_wdata)),
    .cfg_q (cfg_q)
  );

  gcb_lowest_pick #(.LINES(LINES)) u_pick (
    .sel    (mask_q),
    .cfg    (cfg_q),
    .picked (cfg_rd)
  );

  gcb_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pins_sync)
  );

  // mask and output latch
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      latch_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MASK:  mask_q  <= bus_wdata[LINES-1:0];
        A_SET:   latch_q <= latch_q | bus_wdata[LINES-1:0];
        A_CLR:   latch_q <= latch_q & ~bus_wdata[LINES-1:0];
        default: ;
      endcase
    end
  end

  // read mux, registered
  always_comb begin
    case (bus_addr)
      A_MASK:  rd_next = widen(mask_q);
      A_CFG:   rd_next = cfg_to_word(cfg_rd);
      A_PINS:  rd_next = widen(pins_sync);
      A_OUTS:  rd_next = widen(latch_q);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // pad-side fan-out straight from the stored flops
  assign pad_out = latch_q;
  for (genvar n = 0; n < LINES; n++) begin : g_pad
    assign pad_dir[n]           = cfg_q[n].dir;
    assign pad_func[3*n +: 3]   = cfg_q[n].func;
    assign pad_pull_up[n]       = cfg_q[n].pull_up;
    assign pad_pull_dn[n]       = cfg_q[n].pull_dn;
    assign pad_odrain[n]        = cfg_q[n].odrain;
    assign pad_drive[2*n +: 2]  = cfg_q[n].drive;
  end
endmodule

// File: rtl/gcb_bank_chk.sv
module gcb_bank_chk
  import gcb_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [LINES-1:0]  pad_in,
  input logic [LINES-1:0]  pad_out,
  input logic [LINES-1:0]  pad_dir,
  input logic [LINES-1:0]  mask_q
);
  // cycles since reset, saturating; gates properties that look back
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 3) age <= age + 1'b1;
  end
  logic warm;
  assign warm = (age == 3);

  assert_set_R7: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(bus_wr && bus_addr == ADDR_W'(OFS_SET))) |->
      pad_out == ($past(pad_out) | $past(bus_wdata[LINES-1:0])));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(bus_wr && bus_addr == ADDR_W'(OFS_CLR))) |->
      pad_out == ($past(pad_out) & ~$past(bus_wdata[LINES-1:0])));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(bus_wr && (bus_addr == ADDR_W'(OFS_SET) ||
                               bus_addr == ADDR_W'(OFS_CLR)))) |->
      $stable(pad_out));

  assert_broadcast_R3: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(bus_wr && bus_addr == ADDR_W'(OFS_CFG))) |->
      pad_dir == (($past(mask_q) & {LINES{$past(bus_wdata[8])}}) |
                  (~$past(mask_q) & $past(pad_dir))));

  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(bus_addr == ADDR_W'(OFS_CFG) && mask_q == '0)) |->
      bus_rdata == '0);

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(bus_addr == ADDR_W'(OFS_CFG))) |->
      (bus_rdata & ~CFG_IMPL) == '0);

  assert_pin_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(bus_addr == ADDR_W'(OFS_PINS))) |->
      bus_rdata[LINES-1:0] == $past(pad_in, 3));
endmodule

bind gcb_bank gcb_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_dir   (pad_dir),
  .mask_q    (mask_q)
);

// File: tb/gcb_bank_test.sv
module gcb_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [5:0]        bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [LINES-1:0]  pad_in = '0;
  logic [LINES-1:0]  pad_out, pad_dir, pad_pull_up, pad_pull_dn, pad_odrain;
  logic [3*LINES-1:0] pad_func;
  logic [2*LINES-1:0] pad_drive;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcb_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_dir(pad_dir), .pad_func(pad_func),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_odrain(pad_odrain), .pad_drive(pad_drive)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 rdata", 96'(bus_rdata), 96'h0);
    check("R1 pad_out", 96'(pad_out), 96'h0);
    check("R1 pad_dir", 96'(pad_dir), 96'h0);
    check("R1 pad_func", 96'(pad_func), 96'h0);
    bus_read(6'h00, r); check("R1 mask", 96'(r), 96'h0);
    bus_read(6'h18, r); check("R1 latch", 96'(r), 96'h0);
  endtask

  task automatic t_mask_rw();
    logic [31:0] r;
    bus_write(6'h00, 32'hA5A5_5A5A);
    bus_read(6'h00, r); check("R2 mask readback", 96'(r), 96'hA5A5_5A5A);
  endtask

  task automatic t_broadcast();
    logic [31:0] r;
    bus_write(6'h00, 32'h0000_00F0);
    bus_write(6'h04, 32'h0001_0103);
    bus_write(6'h00, 32'h0000_0001);
    bus_write(6'h04, 32'h0000_0200);
    check("R3 dir after group write", 96'(pad_dir), 96'h0000_00F0);
    check("R3 pull-up single line", 96'(pad_pull_up), 96'h0000_0001);
    bus_write(6'h00, 32'h0000_0020);
    bus_read(6'h04, r); check("R3 line5 word", 96'(r), 96'h0001_0103);
    bus_write(6'h00, 32'h0000_0002);
    bus_read(6'h04, r); check("R3 unselected line1 untouched", 96'(r), 96'h0);
  endtask

  task automatic t_lowest();
    logic [31:0] r;
    bus_write(6'h00, 32'h8000_0011);
    bus_read(6'h04, r); check("R4 lowest is line0", 96'(r), 96'h0000_0200);
    bus_write(6'h00, 32'h0);
    bus_read(6'h04, r); check("R4 empty mask reads zero", 96'(r), 96'h0);
    bus_write(6'h00, 32'h8000_0000);
    bus_write(6'h04, 32'h0003_C007);
    bus_read(6'h04, r); check("R4 top line alone", 96'(r), 96'h0003_C007);
    bus_write(6'h00, 32'h8000_0010);
    bus_read(6'h04, r); check("R4 line4 beats line31", 96'(r), 96'h0001_0103);
  endtask

  task automatic t_layout();
    logic [31:0] r;
    bus_write(6'h00, 32'h0000_0200);
    bus_write(6'h04, 32'hFFFF_FFFF);
    bus_read(6'h04, r); check("R5 reserved bits zero", 96'(r), 96'h0003_FF07);
    check("R6 func line9", 96'(pad_func[29:27]), 96'h7);
    check("R6 drive line9", 96'(pad_drive[19:18]), 96'h3);
    check("R6 odrain", 96'(pad_odrain), 96'h8000_0200);
    check("R6 pull-down", 96'(pad_pull_dn), 96'h0000_0200);
    check("R6 func line5", 96'(pad_func[17:15]), 96'h3);
    check("R6 drive line5", 96'(pad_drive[11:10]), 96'h1);
  endtask

  task automatic t_set_clear();
    logic [31:0] r;
    bus_write(6'h10, 32'h0000_F00F);
    bus_read(6'h18, r); check("R7 first set", 96'(r), 96'h0000_F00F);
    bus_write(6'h10, 32'h0000_0F00);
    check("R7 set keeps others", 96'(pad_out), 96'h0000_FF0F);
    bus_write(6'h14, 32'h0000_000F);
    bus_read(6'h18, r); check("R8 clear", 96'(r), 96'h0000_FF00);
    bus_write(6'h14, 32'h0);
    check("R9 pad_out follows latch", 96'(pad_out), 96'h0000_FF00);
    bus_read(6'h10, r); check("R11 set reg reads zero", 96'(r), 96'h0);
  endtask

  task automatic t_pins();
    logic [31:0] r1, r2, r3;
    pad_in = 32'h1234_5678;
    bus_read(6'h08, r1);
    bus_read(6'h08, r2);
    bus_read(6'h08, r3);
    check("R10 first read still old", 96'(r1), 96'h0);
    check("R10 second read still old", 96'(r2), 96'h0);
    check("R10 third read new", 96'(r3), 96'h1234_5678);
  endtask

  task automatic t_ignored();
    logic [31:0] r;
    bus_write(6'h00, 32'h0000_0020);
    bus_write(6'h08, 32'hFFFF_FFFF);
    bus_write(6'h18, 32'hFFFF_FFFF);
    bus_write(6'h20, 32'hFFFF_FFFF);
    bus_write(6'h3C, 32'hFFFF_FFFF);
    bus_read(6'h18, r); check("R11 latch untouched", 96'(r), 96'h0000_FF00);
    bus_read(6'h00, r); check("R11 mask untouched", 96'(r), 96'h0000_0020);
    bus_read(6'h04, r); check("R11 config untouched", 96'(r), 96'h0001_0103);
    bus_read(6'h20, r); check("R11 unmapped reads zero", 96'(r), 96'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_mask_rw();
    t_broadcast();
    t_lowest();
    t_layout();
    t_set_clear();
    t_pins();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule